// File: doc/BRIEF.md
# I2C Slave Status and Overrun Flag Register

This block is the status and interrupt flag register for an I2C slave engine. The engine reports bus events as single-cycle strobes: start, stop, end of transmit byte, end of receive byte, ACK/NAK sent, ACK received and NAK received. The block turns each strobe into a 3-bit status code and an operation-complete flag. It also holds a busy flag that a start-operation trigger sets, and it drives an operation-complete interrupt.

The block tracks the two-stage receive path: a receive buffer, plus a shift register that holds a second received byte while the buffer is still unread. An overrun is flagged when a new trigger arrives while both stages hold unread bytes. A receive-error interrupt follows the overrun flag when its enable is set. To recover, software writes 1 to the error bit and then reads the buffer twice, which drains both stages.

The CPU reads an 8-bit register. Only the two flag bits respond to writes, and both are cleared by writing 1.

Top module: `i2cs_flag_reg`

## Requirements
- R1: After reset, `reg_o` reads 0x00 and both `cmp_irq_o` and `err_irq_o` are low.
- R2: Bits 7:6 of `reg_o` always read 0. Writes to bits 7:2 have no effect on `reg_o`.
- R3: A strobe on `evt_i[k]` loads code k into `reg_o[4:2]` and sets `reg_o[0]` on the next clock. The codes are: 0 start, 1 stop, 2 transmit byte end, 3 receive byte end, 4 ACK/NAK sent, 5 ACK received, 6 NAK received. When several strobes arrive together, the highest index wins, so code 7 never appears.
- R4: `trig_i` sets busy bit `reg_o[5]` on the next clock. Any event strobe clears busy. If a trigger and an event arrive in the same cycle, the trigger wins.
- R5: Writing 1 to bit 0 clears `reg_o[0]` and returns `reg_o[4:2]` to 0. An event strobe in the same cycle takes priority over that clear. Writing 0 to bit 0 has no effect.
- R6: `cmp_irq_o` is high exactly while `reg_o[0]` is 1.
- R7: Overrun bit `reg_o[1]` is set on the clock after `trig_i` only when both the receive buffer and the shift register hold unread bytes. In every other case it does not set.
- R8: `reg_o[1]` is cleared only by a write with bit 1 equal to 1. A write with bit 1 equal to 0 leaves it unchanged. A new overrun in the same cycle as the clear wins.
- R9: `err_irq_o` is high whenever `reg_o[1]` is 1 and `err_ie_i` is 1, including the first cycle the flag is set.
- R10: A receive-end strobe fills the buffer first and then the shift register. A third byte is dropped. A pulse on `rd_buf_i` moves a shift-register byte into the buffer, or empties the buffer if the shift register is empty. Two reads therefore drain both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | Event strobes from the slave engine, bit index = status code |
| trig_i | input | 1 | Start-operation trigger write |
| rd_buf_i | input | 1 | Receive-buffer read strobe |
| wr_en_i | input | 1 | CPU write enable for this register |
| wr_data_i | input | 8 | CPU write data |
| err_ie_i | input | 1 | Receive-error interrupt enable |
| reg_o | output | 8 | Register read value |
| cmp_irq_o | output | 1 | Operation-complete interrupt |
| err_irq_o | output | 1 | Receive-error interrupt |

## Verification
The bench builds the block with its default of seven event strobes and a 3-bit code. At that size it can sweep every single strobe and all 127 non-empty strobe combinations against an arithmetically computed highest index. It also sweeps all 256 write values over a register preloaded with busy, a nonzero code and the complete flag. The receive path is walked through every occupancy state (empty, one byte, two bytes, dropped third byte) with triggers, reads and same-cycle clear races, so each overrun and drain case is observed through the error bit.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int NUM_EVT = 7;
  localparam int CODE_W  = 3;
  localparam int REG_W   = 8;

  typedef enum logic [CODE_W-1:0] {
    EV_START    = 3'd0,
    EV_STOP     = 3'd1,
    EV_TX_END   = 3'd2,
    EV_RX_END   = 3'd3,
    EV_ACKNAK_S = 3'd4,
    EV_ACK_R    = 3'd5,
    EV_NAK_R    = 3'd6
  } evt_code_e;

  localparam int BIT_CMP  = 0;
  localparam int BIT_ERR  = 1;
  localparam int BIT_CODE = 2;
  localparam int BIT_BUSY = BIT_CODE + CODE_W;
endpackage

// File: rtl/i2cs_evt_enc.sv
module i2cs_evt_enc #(
  parameter int NUM_EVT = 7,
  parameter int CODE_W  = 3
) (
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               any_o,
  output logic [CODE_W-1:0]  code_o
);
  // later index overrides: highest strobe wins
  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt_i[i]) code_o = CODE_W'(i);
    end
  end
  assign any_o = |evt_i;
endmodule

// File: rtl/i2cs_rx_occ.sv
module i2cs_rx_occ (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_end_i,
  input  logic rd_buf_i,
  input  logic trig_i,
  output logic ovr_o
);
  logic buf_q, shr_q, buf_d, shr_d;

  always_comb begin
    buf_d = buf_q;
    shr_d = shr_q;
    if (rd_buf_i && buf_d) begin
      if (shr_d) shr_d = 1'b0;
      else       buf_d = 1'b0;
    end
    if (rx_end_i) begin
      if (!buf_d)      buf_d = 1'b1;
      else if (!shr_d) shr_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= 1'b0;
      shr_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      shr_q <= shr_d;
    end
  end

  assign ovr_o = trig_i && buf_q && shr_q;
endmodule

// File: rtl/i2cs_flag_core.sv
module i2cs_flag_core #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_any_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              trig_i,
  input  logic              ovr_i,
  input  logic              clr_cmp_i,
  input  logic              clr_err_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o,
  output logic              cmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      code_o <= '0;
      err_o  <= 1'b0;
      cmp_o  <= 1'b0;
    end else begin
      if (trig_i)         busy_o <= 1'b1;
      else if (evt_any_i) busy_o <= 1'b0;

      if (evt_any_i) begin
        code_o <= evt_code_i;
        cmp_o  <= 1'b1;
      end else if (clr_cmp_i) begin
        code_o <= '0;
        cmp_o  <= 1'b0;
      end

      if (ovr_i)          err_o <= 1'b1;
      else if (clr_err_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_flag_reg.sv
module i2cs_flag_reg
  import i2cs_pkg::*;
#(
  parameter int N_EVT  = NUM_EVT,
  parameter int C_W    = CODE_W,
  parameter int R_W    = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             trig_i,
  input  logic             rd_buf_i,
  input  logic             wr_en_i,
  input  logic [R_W-1:0]   wr_data_i,
  input  logic             err_ie_i,
  output logic [R_W-1:0]   reg_o,
  output logic             cmp_irq_o,
  output logic             err_irq_o
);
  localparam int RSVD_LO = BIT_BUSY + 1;

  logic           evt_any, ovr, busy, err, cmp;
  logic [C_W-1:0] evt_code, code;

  i2cs_evt_enc #(.NUM_EVT(N_EVT), .CODE_W(C_W)) u_enc (
    .evt_i (evt_i),
    .any_o (evt_any),
    .code_o(evt_code)
  );

  i2cs_rx_occ u_occ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_end_i(evt_i[EV_RX_END]),
    .rd_buf_i(rd_buf_i),
    .trig_i  (trig_i),
    .ovr_o   (ovr)
  );

  i2cs_flag_core #(.CODE_W(C_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_any_i (evt_any),
    .evt_code_i(evt_code),
    .trig_i    (trig_i),
    .ovr_i     (ovr),
    .clr_cmp_i (wr_en_i && wr_data_i[BIT_CMP]),
    .clr_err_i (wr_en_i && wr_data_i[BIT_ERR]),
    .busy_o    (busy),
    .code_o    (code),
    .err_o     (err),
    .cmp_o     (cmp)
  );

  generate
    for (genvar g = RSVD_LO; g < R_W; g++) begin : g_rsvd
      assign reg_o[g] = 1'b0;
    end
  endgenerate

  assign reg_o[BIT_BUSY]                 = busy;
  assign reg_o[BIT_CODE +: C_W]          = code;
  assign reg_o[BIT_ERR]                  = err;
  assign reg_o[BIT_CMP]                  = cmp;
  assign cmp_irq_o                       = cmp;
  assign err_irq_o                       = err && err_ie_i;
endmodule

// File: rtl/i2cs_flag_reg_chk.sv
module i2cs_flag_reg_chk #(
  parameter int N_EVT = 7,
  parameter int R_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EVT-1:0] evt_i,
  input logic             trig_i,
  input logic             wr_en_i,
  input logic [R_W-1:0]   wr_data_i,
  input logic             err_ie_i,
  input logic [R_W-1:0]   reg_o,
  input logic             cmp_irq_o,
  input logic             err_irq_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_o[7:6] == 2'b00); // R2
  AST_EVT_SETS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> reg_o[0]); // R3
  AST_CODE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_o[4:2] != 3'd7); // R3
  AST_TRIG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> reg_o[5]); // R4
  AST_EVT_CLR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|evt_i) && !trig_i) |=> !reg_o[5]); // R4
  AST_CLR_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && !(|evt_i)) |=> (!reg_o[0] && reg_o[4:2] == 3'd0)); // R5
  AST_CMP_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_o[0]) |-> cmp_irq_o); // R6
  AST_NO_SPURIOUS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_o[1] && !trig_i) |=> !reg_o[1]); // R7
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_o[1] && !(wr_en_i && wr_data_i[1])) |=> reg_o[1]); // R8
  AST_ERR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(reg_o[1]) && err_ie_i) |-> err_irq_o); // R9
endmodule

bind i2cs_flag_reg i2cs_flag_reg_chk #(.N_EVT(N_EVT), .R_W(R_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .trig_i   (trig_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .err_ie_i (err_ie_i),
  .reg_o    (reg_o),
  .cmp_irq_o(cmp_irq_o),
  .err_irq_o(err_irq_o)
);

// File: tb/i2cs_flag_reg_tb.sv
`timescale 1ns/1ps
module i2cs_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic       trig = 1'b0, rd = 1'b0, wr_en = 1'b0, ie = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] rv;
  logic       cirq, eirq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2cs_flag_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .trig_i(trig), .rd_buf_i(rd),
    .wr_en_i(wr_en), .wr_data_i(wdat), .err_ie_i(ie),
    .reg_o(rv), .cmp_irq_o(cirq), .err_irq_o(eirq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive for one clock, starting and ending at a falling edge
  task automatic cyc(input logic [6:0] e, input logic t, input logic r,
                     input logic w, input logic [7:0] d);
    evt = e; trig = t; rd = r; wr_en = w; wdat = d;
    @(negedge clk);
    evt = '0; trig = 1'b0; rd = 1'b0; wr_en = 1'b0; wdat = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk(rv, 8'h00, "R1 reg");
    chk({7'd0, cirq}, 8'd0, "R1 cmp_irq");
    chk({7'd0, eirq}, 8'd0, "R1 err_irq");

    // R3: single strobes
    for (int k = 0; k < 7; k++) begin
      cyc(7'(1 << k), 1'b0, 1'b0, 1'b0, 8'h00);
      chk({3'd0, rv[4:2]}, 8'(k), "R3 single code");
      chk({7'd0, rv[0]}, 8'd1, "R3 single cmp");
      chk({7'd0, cirq}, 8'd1, "R6 irq follows cmp");
    end
    // R3: every combination, highest index wins
    for (int m = 1; m < 128; m++) begin
      int hi = 0;
      for (int b = 0; b < 7; b++) if (m[b]) hi = b;
      cyc(7'(m), 1'b0, 1'b0, 1'b0, 8'h00);
      chk({3'd0, rv[4:2]}, 8'(hi), "R3 priority");
    end

    // R2 and R5: write sweep over preloaded state
    for (int w = 0; w < 256; w++) begin
      do_reset();
      cyc(7'h40, 1'b0, 1'b0, 1'b0, 8'h00);
      cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
      chk(rv, 8'h39, "R2 preload");
      cyc(7'h00, 1'b0, 1'b0, 1'b1, 8'(w));
      if (w[0]) chk(rv, 8'h20, "R5 write1 clears cmp/code");
      else      chk(rv, 8'h39, "R2 upper bits ignored");
    end
    chk({7'd0, cirq}, 8'd0, "R6 irq low after clear");

    // R5: event beats clear
    do_reset();
    cyc(7'h01, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(7'h20, 1'b0, 1'b0, 1'b1, 8'h01);
    chk(rv, 8'h15, "R5 event beats clear");

    // R4
    do_reset();
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[5]}, 8'd1, "R4 trig sets busy");
    cyc(7'h02, 1'b0, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[5]}, 8'd0, "R4 event clears busy");
    cyc(7'h02, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[5]}, 8'd1, "R4 trig wins");

    // R7, R10 occupancy walk
    do_reset();
    ie = 1'b0;
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd0, "R7 empty no ovr");
    cyc(7'h08, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd0, "R7 one byte no ovr");
    cyc(7'h08, 1'b0, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd0, "R7 no trig no ovr");
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd1, "R7 two bytes ovr");
    chk({7'd0, eirq}, 8'd0, "R9 disabled");
    ie = 1'b1;
    #1;
    chk({7'd0, eirq}, 8'd1, "R9 enabled");
    // R8
    cyc(7'h00, 1'b0, 1'b0, 1'b1, 8'hFD);
    chk({7'd0, rv[1]}, 8'd1, "R8 write0 ignored");
    cyc(7'h00, 1'b1, 1'b0, 1'b1, 8'h02);
    chk({7'd0, rv[1]}, 8'd1, "R8 set beats clear");
    cyc(7'h00, 1'b0, 1'b0, 1'b1, 8'h02);
    chk({7'd0, rv[1]}, 8'd0, "R8 write1 clears");
    chk({7'd0, eirq}, 8'd0, "R9 low after clear");
    // R10 drain
    cyc(7'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd0, "R10 one read leaves one byte");
    cyc(7'h08, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(7'h08, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd1, "R10 refill third byte dropped");
    cyc(7'h00, 1'b0, 1'b0, 1'b1, 8'h02);
    cyc(7'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(7'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(7'h08, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd0, "R10 two reads drain");
    cyc(7'h08, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(7'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    chk({7'd0, rv[1]}, 8'd0, "R10 read and rx same cycle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule